// File: doc/BRIEF.md
# Reselection Identify and Queue Tag Checker

This block runs on the initiator side of a parallel peripheral bus after a target that disconnected earlier comes back and reselects the initiator. It first checks that the reselecting device is the target the initiator is waiting for. It then checks the Identify message byte that follows against the stored logical unit context. When the stored context says a queued command is outstanding, it also checks a two-byte simple queue tag message. Each accepted step moves a progress code forward. A failed check ends the sequence with an interrupt code that names the kind of mismatch.

Bus handshaking, parity checking and the data phase are handled outside this block. Surrounding logic raises a one-cycle reselection strobe that carries the reselecting device's ID. It then hands over each received message byte with its own one-cycle valid strobe. The block answers every strobe one clock later. On success it raises a done pulse. On failure it raises an error pulse with an interrupt code and, for a tag mismatch, asks for the received tag to be written back into the queue tag register.

Top module: `resel_msg_checker`

## Requirements
- R1: After reset the progress output reads 0x43, and done, error and tag write are low with interrupt code 0x00.
- R2: A reselection strobe whose ID equals the expected destination ID sets progress to 0x44 one clock later with no pulse, and the block then waits for the Identify byte.
- R3: A reselection strobe whose ID differs from the destination ID gives an error pulse with code 0x4B one clock later. Progress is left unchanged and message bytes are then ignored.
- R4: The Identify byte is accepted only if bit 7 is 1, bits 5, 4 and 3 are 0, bit 6 equals bit 6 of the LUN context and bits 2:0 equal bits 2:0 of the LUN context. Any other byte gives an error pulse with code 0x4F and leaves progress at 0x44.
- R5: An accepted Identify byte with the tag-expected flag low sets progress to 0x45 and gives a done pulse with code 0x00.
- R6: An accepted Identify byte with the tag-expected flag high sets progress to 0x70 with no pulse.
- R7: The first tag byte is accepted only if it equals the simple queue tag code 0x20, and acceptance sets progress to 0x71. Any other value gives an error pulse with code 0x4F and leaves progress at 0x70.
- R8: The second tag byte sets progress to 0x45. If it equals the queue tag register, a done pulse follows. If it differs, an error pulse with code 0x26 comes with a one-cycle tag write carrying the received byte.
- R9: A reselection strobe in any step restarts the check at the Identify step. It takes priority over a byte strobe in the same cycle.
- R10: A byte strobe while no check is in progress (after reset, after done or after an error) changes no output.
- R11: Done and error are never high together, and a tag write occurs only together with the 0x26 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resel_stb | input | 1 | One-cycle reselection event |
| resel_id | input | ID_W | ID of the reselecting device |
| dest_id | input | ID_W | ID of the expected target |
| lun_ctx | input | 8 | LUN context: bit 6 disconnect privilege, bits 2:0 LUN |
| tag_expected | input | 1 | A queue tag message must follow the Identify byte |
| tag_ctx | input | 8 | Stored queue tag value |
| msg_stb | input | 1 | One-cycle valid for msg_byte |
| msg_byte | input | 8 | Received message byte |
| phase_q | output | 8 | Progress code |
| done_pulse | output | 1 | Sequence accepted |
| err_pulse | output | 1 | Sequence rejected |
| irq_code | output | 8 | Interrupt code, valid with err_pulse, 0x00 otherwise |
| tag_wr_en | output | 1 | Write tag_wr_data into the queue tag register |
| tag_wr_data | output | 8 | Received tag byte to store |

## Verification
The hardest case to reach is the tag write-back. It happens only after a matching reselection, a fully correct Identify byte with the tag flag raised, and an exact simple tag code, all in sequence with no restart in between. The stimulus walks that full chain and then offers a second tag byte that differs from the stored tag. It also restarts the chain partway through, using a reselection strobe that coincides with a byte strobe, so the priority rule and the return to the Identify step are both exercised.

// File: rtl/resel_chk_pkg.sv
package resel_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_IDENT = 2'd1,
        ST_TAG1  = 2'd2,
        ST_TAG2  = 2'd3
    } chk_state_e;

    localparam logic [7:0] PH_DISCONNECTED = 8'h43;
    localparam logic [7:0] PH_RESELECTED   = 8'h44;
    localparam logic [7:0] PH_READY        = 8'h45;
    localparam logic [7:0] PH_WANT_TAG     = 8'h70;
    localparam logic [7:0] PH_TAG_CODE_OK  = 8'h71;

    localparam logic [7:0] IRQ_NONE        = 8'h00;
    localparam logic [7:0] IRQ_FOREIGN     = 8'h4B;
    localparam logic [7:0] IRQ_BAD_MSG     = 8'h4F;
    localparam logic [7:0] IRQ_TAG_DIFFERS = 8'h26;

    typedef struct packed {
        chk_state_e  st;
        logic [7:0]  phase;
        logic        done;
        logic        err;
        logic [7:0]  code;
        logic        wr;
        logic [7:0]  wdata;
    } chk_regs_t;

endpackage

// File: rtl/resel_ident_check.sv
module resel_ident_check #(
    parameter int LUN_W = 3
) (
    input  logic [7:0] msg,
    input  logic [7:0] lun_ctx,
    output logic       ok
);
    localparam int RSV_LO = LUN_W;
    localparam int RSV_HI = 5;

    logic rsv_clear;
    logic lun_same;
    logic priv_same;

    always_comb begin
        rsv_clear = (msg[RSV_HI:RSV_LO] == '0);
        lun_same  = (msg[LUN_W-1:0] == lun_ctx[LUN_W-1:0]);
        priv_same = (msg[6] == lun_ctx[6]);
        ok        = msg[7] && rsv_clear && lun_same && priv_same;
    end

endmodule

// File: rtl/resel_tag_check.sv
module resel_tag_check #(
    parameter logic [7:0] SIMPLE_CODE = 8'h20
) (
    input  logic [7:0] msg,
    input  logic [7:0] tag_ctx,
    output logic       code_ok,
    output logic       tag_eq
);
    always_comb begin
        code_ok = (msg == SIMPLE_CODE);
        tag_eq  = (msg == tag_ctx);
    end

endmodule

// File: rtl/resel_msg_checker.sv
module resel_msg_checker
    import resel_chk_pkg::*;
#(
    parameter int         ID_W        = 3,
    parameter int         LUN_W       = 3,
    parameter logic [7:0] SIMPLE_CODE = 8'h20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resel_stb,
    input  logic [ID_W-1:0] resel_id,
    input  logic [ID_W-1:0] dest_id,
    input  logic [7:0]      lun_ctx,
    input  logic            tag_expected,
    input  logic [7:0]      tag_ctx,
    input  logic            msg_stb,
    input  logic [7:0]      msg_byte,
    output logic [7:0]      phase_q,
    output logic            done_pulse,
    output logic            err_pulse,
    output logic [7:0]      irq_code,
    output logic            tag_wr_en,
    output logic [7:0]      tag_wr_data
);
    chk_regs_t r_q;
    chk_regs_t r_d;

    logic ident_ok;
    logic code_ok;
    logic tag_eq;
    logic id_match;

    resel_ident_check #(.LUN_W(LUN_W)) u_ident (
        .msg     (msg_byte),
        .lun_ctx (lun_ctx),
        .ok      (ident_ok)
    );

    resel_tag_check #(.SIMPLE_CODE(SIMPLE_CODE)) u_tag (
        .msg     (msg_byte),
        .tag_ctx (tag_ctx),
        .code_ok (code_ok),
        .tag_eq  (tag_eq)
    );

    assign id_match = (resel_id == dest_id);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        r_d.code  = IRQ_NONE;
        r_d.wr    = 1'b0;
        r_d.wdata = 8'h00;
        if (resel_stb) begin
            if (id_match) begin
                r_d.phase = PH_RESELECTED;
                r_d.st    = ST_IDENT;
            end else begin
                r_d.err  = 1'b1;
                r_d.code = IRQ_FOREIGN;
                r_d.st   = ST_IDLE;
            end
        end else if (msg_stb) begin
            case (r_q.st)
                ST_IDENT: begin
                    if (!ident_ok) begin
                        r_d.err  = 1'b1;
                        r_d.code = IRQ_BAD_MSG;
                        r_d.st   = ST_IDLE;
                    end else if (tag_expected) begin
                        r_d.phase = PH_WANT_TAG;
                        r_d.st    = ST_TAG1;
                    end else begin
                        r_d.phase = PH_READY;
                        r_d.done  = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
                ST_TAG1: begin
                    if (code_ok) begin
                        r_d.phase = PH_TAG_CODE_OK;
                        r_d.st    = ST_TAG2;
                    end else begin
                        r_d.err  = 1'b1;
                        r_d.code = IRQ_BAD_MSG;
                        r_d.st   = ST_IDLE;
                    end
                end
                ST_TAG2: begin
                    r_d.phase = PH_READY;
                    r_d.st    = ST_IDLE;
                    if (tag_eq) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.err   = 1'b1;
                        r_d.code  = IRQ_TAG_DIFFERS;
                        r_d.wr    = 1'b1;
                        r_d.wdata = msg_byte;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.phase <= PH_DISCONNECTED;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
            r_q.code  <= IRQ_NONE;
            r_q.wr    <= 1'b0;
            r_q.wdata <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_q     = r_q.phase;
    assign done_pulse  = r_q.done;
    assign err_pulse   = r_q.err;
    assign irq_code    = r_q.code;
    assign tag_wr_en   = r_q.wr;
    assign tag_wr_data = r_q.wdata;

    // R2: matching reselection lands on 0x44 quietly
    a_r2_resel_match: assert property (@(posedge clk) disable iff (!rst_n)
        (resel_stb && resel_id == dest_id) |=>
            (phase_q == PH_RESELECTED && !done_pulse && !err_pulse));

    // R3: foreign reselection raises 0x4B and keeps progress
    a_r3_resel_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (resel_stb && resel_id != dest_id) |=>
            (err_pulse && irq_code == IRQ_FOREIGN && $stable(phase_q)));

    // R4, R7: a rejected message byte leaves progress where it was
    a_r4_bad_msg_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && irq_code == IRQ_BAD_MSG) |-> (phase_q == $past(phase_q)));

    // R10: with no strobe nothing moves
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!resel_stb && !msg_stb) |=> (!done_pulse && !err_pulse && !tag_wr_en && $stable(phase_q)));

    // R11: results are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, err_pulse}));

    // R8, R11: write-back only on a tag difference, with a differing value
    a_r8_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr_en |-> (err_pulse && irq_code == IRQ_TAG_DIFFERS &&
                       phase_q == PH_READY && tag_wr_data != $past(tag_ctx)));

endmodule

// File: tb/resel_msg_checker_bench.sv
module resel_msg_checker_bench;

    typedef struct packed {
        logic [7:0] ph;
        logic       dn;
        logic       er;
        logic [7:0] cd;
        logic       wr;
        logic [7:0] wd;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       resel_stb = 1'b0;
    logic [2:0] resel_id = 3'd0;
    logic [2:0] dest_id = 3'd3;
    logic [7:0] lun_ctx = 8'h45;
    logic       tag_expected = 1'b0;
    logic [7:0] tag_ctx = 8'h5A;
    logic       msg_stb = 1'b0;
    logic [7:0] msg_byte = 8'h00;
    logic [7:0] phase_q;
    logic       done_pulse;
    logic       err_pulse;
    logic [7:0] irq_code;
    logic       tag_wr_en;
    logic [7:0] tag_wr_data;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    resel_msg_checker u_resel_msg_checker (
        .clk(clk), .rst_n(rst_n), .resel_stb(resel_stb), .resel_id(resel_id),
        .dest_id(dest_id), .lun_ctx(lun_ctx), .tag_expected(tag_expected),
        .tag_ctx(tag_ctx), .msg_stb(msg_stb), .msg_byte(msg_byte),
        .phase_q(phase_q), .done_pulse(done_pulse), .err_pulse(err_pulse),
        .irq_code(irq_code), .tag_wr_en(tag_wr_en), .tag_wr_data(tag_wr_data)
    );

    task automatic compare(input exp_t e, input string req);
        exp_t a;
        a = '{ph: phase_q, dn: done_pulse, er: err_pulse, cd: irq_code,
              wr: tag_wr_en, wd: tag_wr_data};
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s: actual ph=%h dn=%b er=%b cd=%h wr=%b wd=%h expected ph=%h dn=%b er=%b cd=%h wr=%b wd=%h",
                     req, a.ph, a.dn, a.er, a.cd, a.wr, a.wd,
                     e.ph, e.dn, e.er, e.cd, e.wr, e.wd);
        end
    endtask

    // driver: one cycle of stimulus plus the result expected one clock later
    task automatic step(input logic rs, input logic [2:0] rid, input logic ms,
                        input logic [7:0] mb, input logic [7:0] ph, input logic dn,
                        input logic er, input logic [7:0] cd, input logic wr,
                        input logic [7:0] wd, input string req);
        @(negedge clk);
        resel_stb = rs;
        resel_id  = rid;
        msg_stb   = ms;
        msg_byte  = mb;
        exp_q.push_back('{ph: ph, dn: dn, er: er, cd: cd, wr: wr, wd: wd});
        tag_q.push_back(req);
    endtask

    task automatic resel_ok(input string req);
        step(1'b1, 3'd3, 1'b0, 8'h00, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, req);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: pops one expected item per clock, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string req;
                e = exp_q.pop_front();
                req = tag_q.pop_front();
                compare(e, req);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare('{ph: 8'h43, dn: 1'b0, er: 1'b0, cd: 8'h00, wr: 1'b0, wd: 8'h00}, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R10: byte with no reselection is ignored
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h43, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R10 idle byte");
        // R3: foreign target
        step(1'b1, 3'd6, 1'b0, 8'h00, 8'h43, 1'b0, 1'b1, 8'h4B, 1'b0, 8'h00, "R3 foreign");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h43, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R3 byte after foreign");
        // R2, R5: plain success
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h45, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R5 ident no tag");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h45, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R10 byte after done");
        // R4: each Identify fault
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC4, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R4 lun differs");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'h85, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R4 priv bit differs");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hE5, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R4 bit5 set");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hCD, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R4 bit3 set");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'h45, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R4 bit7 clear");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R10 byte after error");

        // tagged sequences
        @(negedge clk);
        tag_expected = 1'b1;
        exp_q.push_back('{ph: 8'h44, dn: 1'b0, er: 1'b0, cd: 8'h00, wr: 1'b0, wd: 8'h00});
        tag_q.push_back("R10 hold");
        resel_stb = 1'b0;
        msg_stb = 1'b0;
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R6 ident tag");
        step(1'b0, 3'd0, 1'b1, 8'h21, 8'h70, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R7 non-simple code");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R6 ident tag");
        step(1'b0, 3'd0, 1'b1, 8'h20, 8'h71, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7 simple code");
        step(1'b0, 3'd0, 1'b1, 8'h5A, 8'h45, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R8 tag equal");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R6 ident tag");
        step(1'b0, 3'd0, 1'b1, 8'h20, 8'h71, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7 simple code");
        step(1'b0, 3'd0, 1'b1, 8'h33, 8'h45, 1'b0, 1'b1, 8'h26, 1'b1, 8'h33, "R8 tag differs");
        step(1'b0, 3'd0, 1'b0, 8'h00, 8'h45, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R8 write one cycle");
        // R9: restart mid-sequence, reselection beats a same-cycle byte
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R6 ident tag");
        step(1'b1, 3'd3, 1'b1, 8'h20, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R9 restart priority");
        step(1'b0, 3'd0, 1'b1, 8'h20, 8'h44, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h00, "R9 back at identify");
        resel_ok("R2 match");
        step(1'b0, 3'd0, 1'b1, 8'hC5, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R6 ident tag");
        step(1'b0, 3'd0, 1'b1, 8'h20, 8'h71, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7 simple code");
        step(1'b1, 3'd5, 1'b0, 8'h00, 8'h71, 1'b0, 1'b1, 8'h4B, 1'b0, 8'h00, "R3 foreign mid tag");
        step(1'b0, 3'd0, 1'b1, 8'h5A, 8'h71, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R10 byte after foreign");
        step(1'b0, 3'd0, 1'b0, 8'h00, 8'h71, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R11 idle");

        repeat (3) @(posedge clk);
        #2;
        summary();
    end

endmodule